// File: doc/BRIEF.md
# Ripple Magnitude Comparator

This block compares two unsigned words and reports whether the first is greater than, equal to, or less than the second. It is built as a row of identical one-bit stages. Each stage receives a three-flag summary of how the bits below it compare. It combines that summary with its own pair of bits and passes an updated summary to the stage above. The flags leaving the most significant stage are the result.

The flags entering bit 0 are brought out as ports. A caller that compares a single word ties them to "equal", which means greater clear, equal set and less clear. Two or more instances can be stacked to compare a wider word: the result flags of the lower instance drive the cascade inputs of the upper one. The block has no clock and no state. Its outputs follow the inputs combinationally.

Top module: `mag_cmp_chain`

## Requirements
- R1: With cascade inputs {greater, equal, less} = {0,1,0} and A > B as unsigned numbers, the outputs are gt_o=1, eq_o=0, lt_o=0.
- R2: With cascade inputs {0,1,0} and A < B, the outputs are gt_o=0, eq_o=0, lt_o=1.
- R3: With cascade inputs {0,1,0} and A == B, the outputs are gt_o=0, eq_o=1, lt_o=0.
- R4: Whenever exactly one cascade input is 1, exactly one of gt_o, eq_o and lt_o is 1.
- R5: When A differs from B, the most significant differing bit alone decides the result. The lower bits and the cascade inputs have no effect on it.
- R6: When A == B, the outputs copy the cascade inputs bit for bit: gt_o=cas_gt_i, eq_o=cas_eq_i, lt_o=cas_lt_i. This holds for every one of the eight cascade patterns, including patterns that are not one-hot.
- R7: In a one-bit stage whose bits differ, the incoming flags are ignored. a=1, b=0 gives {1,0,0} and a=0, b=1 gives {0,0,1}.
- R8: In a one-bit stage whose bits are equal, the incoming flags pass through unchanged.
- R9: Two instances of width W, with the outputs of the lower instance wired to the cascade inputs of the upper one, compare 2W-bit words correctly. The upper instance takes the high halves and the lower instance takes the low halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First unsigned operand |
| b_i | input | WIDTH | Second unsigned operand |
| cas_gt_i | input | 1 | Flag from lower bits: lower part of A is greater |
| cas_eq_i | input | 1 | Flag from lower bits: lower parts are equal |
| cas_lt_i | input | 1 | Flag from lower bits: lower part of A is less |
| gt_o | output | 1 | A (with lower bits) is greater than B |
| eq_o | output | 1 | A (with lower bits) equals B |
| lt_o | output | 1 | A (with lower bits) is less than B |

## Verification
The embedded assertions check every stage on each evaluation. A stage whose bits differ must ignore its incoming flags, and a stage whose bits match must forward them. At the top, a one-hot cascade input must give a one-hot result, and an equal result may only appear with identical operands. Only the bench's scenarios can show that the flags in fact follow the numeric ordering of the operands. The bench checks this exhaustively against the language's relational operators, for every cascade pattern, and for two stacked instances comparing a double-width word.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;

  // Relation summary of the bits examined so far.
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } cmp_flags_t;

  localparam cmp_flags_t FLAGS_GT = '{gt: 1'b1, eq: 1'b0, lt: 1'b0};
  localparam cmp_flags_t FLAGS_EQ = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};
  localparam cmp_flags_t FLAGS_LT = '{gt: 1'b0, eq: 1'b0, lt: 1'b1};

  // One stage of the ripple: a differing bit pair overrides the lower summary.
  function automatic cmp_flags_t cmp_step(input cmp_flags_t lower,
                                          input logic a_bit,
                                          input logic b_bit);
    cmp_flags_t res;
    res.gt = (a_bit & ~b_bit) | (~(a_bit ^ b_bit) & lower.gt);
    res.lt = (~a_bit & b_bit) | (~(a_bit ^ b_bit) & lower.lt);
    res.eq = ~(a_bit ^ b_bit) & lower.eq;
    return res;
  endfunction

endpackage

// File: rtl/cmp_bit_cell.sv
module cmp_bit_cell
  import mag_cmp_pkg::*;
(
  input  logic       a_bit,
  input  logic       b_bit,
  input  cmp_flags_t low_i,
  output cmp_flags_t up_o
);

  // Named events for the checks below
  logic a_wins;
  logic b_wins;
  logic tie;

  assign a_wins = a_bit & ~b_bit;
  assign b_wins = ~a_bit & b_bit;
  assign tie    = (a_bit == b_bit);

  assign up_o = cmp_step(low_i, a_bit, b_bit);

  always_comb begin
    if (a_wins) begin
      AST_CELL_A_WINS: assert (up_o == FLAGS_GT) else $error("cell: A bit wins but flags %b", up_o); // R7
    end
    if (b_wins) begin
      AST_CELL_B_WINS: assert (up_o == FLAGS_LT) else $error("cell: B bit wins but flags %b", up_o); // R7
    end
    if (tie) begin
      AST_CELL_PASS: assert (up_o == low_i) else $error("cell: tie altered flags %b -> %b", low_i, up_o); // R8
    end
  end

endmodule

// File: rtl/cmp_ripple_chain.sv
module cmp_ripple_chain
  import mag_cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  cmp_flags_t       seed_i,
  output cmp_flags_t       result_o
);

  localparam int STAGES = WIDTH + 1;

  // stage_flags[k] summarises bits k-1..0; stage_flags[0] is the seed
  cmp_flags_t stage_flags [STAGES];

  assign stage_flags[0] = seed_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    cmp_bit_cell u_cell (
      .a_bit (a_i[k]),
      .b_bit (b_i[k]),
      .low_i (stage_flags[k]),
      .up_o  (stage_flags[k+1])
    );
  end

  assign result_o = stage_flags[WIDTH];

endmodule

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain
  import mag_cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cas_gt_i,
  input  logic             cas_eq_i,
  input  logic             cas_lt_i,
  output logic             gt_o,
  output logic             eq_o,
  output logic             lt_o
);

  cmp_flags_t seed;
  cmp_flags_t result;
  logic       seed_valid;
  logic       words_match;

  assign seed        = '{gt: cas_gt_i, eq: cas_eq_i, lt: cas_lt_i};
  assign seed_valid  = ($countones({cas_gt_i, cas_eq_i, cas_lt_i}) == 1);
  assign words_match = (a_i == b_i);

  cmp_ripple_chain #(
    .WIDTH (WIDTH)
  ) u_chain (
    .a_i      (a_i),
    .b_i      (b_i),
    .seed_i   (seed),
    .result_o (result)
  );

  assign gt_o = result.gt;
  assign eq_o = result.eq;
  assign lt_o = result.lt;

  always_comb begin
    if (seed_valid) begin
      AST_ONE_HOT_RESULT: assert ($countones({gt_o, eq_o, lt_o}) == 1) else $error("result not one-hot: %b%b%b", gt_o, eq_o, lt_o); // R4
    end
    if (eq_o) begin
      AST_EQ_NEEDS_MATCH: assert (words_match) else $error("equal flag with differing words"); // R3
    end
    if (words_match) begin
      AST_MATCH_FORWARDS: assert (result == seed) else $error("matching words altered cascade flags"); // R6
    end
  end

endmodule

// File: tb/mag_cmp_chain_test.sv
module mag_cmp_chain_test;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Main instance
  logic [W-1:0] a, b;
  logic cg, ce, cl;
  logic gt, eq, lt;

  mag_cmp_chain #(.WIDTH(W)) uut (
    .a_i(a), .b_i(b), .cas_gt_i(cg), .cas_eq_i(ce), .cas_lt_i(cl),
    .gt_o(gt), .eq_o(eq), .lt_o(lt)
  );

  // Single-bit instance for stage behaviour
  logic a1, b1, g1, e1, l1, go1, eo1, lo1;
  mag_cmp_chain #(.WIDTH(1)) uut_bit (
    .a_i(a1), .b_i(b1), .cas_gt_i(g1), .cas_eq_i(e1), .cas_lt_i(l1),
    .gt_o(go1), .eq_o(eo1), .lt_o(lo1)
  );

  // Stacked pair for double-width compare
  logic [2*W-1:0] wa, wb;
  logic mg, me, ml, hg, he, hl;
  mag_cmp_chain #(.WIDTH(W)) uut_lo (
    .a_i(wa[W-1:0]), .b_i(wb[W-1:0]), .cas_gt_i(1'b0), .cas_eq_i(1'b1), .cas_lt_i(1'b0),
    .gt_o(mg), .eq_o(me), .lt_o(ml)
  );
  mag_cmp_chain #(.WIDTH(W)) uut_hi (
    .a_i(wa[2*W-1:W]), .b_i(wb[2*W-1:W]), .cas_gt_i(mg), .cas_eq_i(me), .cas_lt_i(ml),
    .gt_o(hg), .eq_o(he), .lt_o(hl)
  );

  task automatic report_summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
      report_summary();
    end
  end

  task automatic expect3(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: a=%0d b=%0d actual gel=%b expected gel=%b", req, a, b, act, exp);
    end
  endtask

  // Reference: ordering from relational operators, cascade if equal
  function automatic logic [2:0] ref_cmp(input int x, input int y, input logic [2:0] cas);
    if (x > y) return 3'b100;
    if (x < y) return 3'b001;
    return cas;
  endfunction

  task automatic t_idle();
    a = '0; b = '0; {cg, ce, cl} = 3'b010;
    #1;
    expect3("R3 idle", {gt, eq, lt}, 3'b010);
  endtask

  task automatic t_plain_exhaustive();
    {cg, ce, cl} = 3'b010;
    for (int x = 0; x < (1 << W); x++) begin
      for (int y = 0; y < (1 << W); y++) begin
        a = x[W-1:0]; b = y[W-1:0];
        #1;
        if (x > y)      expect3("R1", {gt, eq, lt}, 3'b100);
        else if (x < y) expect3("R2", {gt, eq, lt}, 3'b001);
        else            expect3("R3", {gt, eq, lt}, 3'b010);
      end
    end
  endtask

  task automatic t_cascade_patterns();
    for (int c = 0; c < 8; c++) begin
      {cg, ce, cl} = c[2:0];
      for (int x = 0; x < (1 << W); x++) begin
        for (int y = 0; y < (1 << W); y++) begin
          a = x[W-1:0]; b = y[W-1:0];
          #1;
          if (x == y) expect3("R6", {gt, eq, lt}, c[2:0]);
          else        expect3("R5", {gt, eq, lt}, ref_cmp(x, y, c[2:0]));
          if (c == 1 || c == 2 || c == 4) begin
            checks = checks + 1;
            if ($countones({gt, eq, lt}) != 1) begin
              errors = errors + 1;
              $display("FAIL R4: actual gel=%b expected one-hot", {gt, eq, lt});
            end
          end
        end
      end
    end
    // Top bit decides even against opposing lower bits
    {cg, ce, cl} = 3'b100;
    a = 4'b1000; b = 4'b0111;
    #1;
    expect3("R5 msb", {gt, eq, lt}, 3'b100);
    a = 4'b0111; b = 4'b1000;
    #1;
    expect3("R5 msb", {gt, eq, lt}, 3'b001);
  endtask

  task automatic t_single_stage();
    for (int c = 0; c < 8; c++) begin
      {g1, e1, l1} = c[2:0];
      a1 = 1'b1; b1 = 1'b0; #1;
      expect3("R7 a wins", {go1, eo1, lo1}, 3'b100);
      a1 = 1'b0; b1 = 1'b1; #1;
      expect3("R7 b wins", {go1, eo1, lo1}, 3'b001);
      a1 = 1'b0; b1 = 1'b0; #1;
      expect3("R8 zeros", {go1, eo1, lo1}, c[2:0]);
      a1 = 1'b1; b1 = 1'b1; #1;
      expect3("R8 ones", {go1, eo1, lo1}, c[2:0]);
    end
  endtask

  task automatic t_stacked();
    for (int x = 0; x < (1 << (2*W)); x++) begin
      for (int y = 0; y < (1 << (2*W)); y++) begin
        wa = x[2*W-1:0]; wb = y[2*W-1:0];
        #1;
        expect3("R9", {hg, he, hl}, ref_cmp(x, y, 3'b010));
      end
    end
  endtask

  initial begin
    a = '0; b = '0; {cg, ce, cl} = 3'b010;
    a1 = 1'b0; b1 = 1'b0; {g1, e1, l1} = 3'b010;
    wa = '0; wb = '0;
    @(negedge clk);
    t_idle();
    t_plain_exhaustive();
    t_cascade_patterns();
    t_single_stage();
    t_stacked();
    @(negedge clk);
    report_summary();
  end

endmodule